// File: doc/BRIEF.md
# Synchronous Dual-Port Byte-Lane RAM

A true dual-port memory of 4096 words by 36 bits. Each of two ports has its own clock and reset and may read or write at any time, independent of the other port. On the rising edge of its clock, a port captures its address, write data and control into input registers. The access itself takes place on the following edge. Read data is therefore registered one cycle after the address.

Each word has four 9-bit lanes, and each lane has its own active-low read/write select. The low half-word (lanes 0 and 1) and the high half-word (lanes 2 and 3) each have their own active-low chip select, active-high input hold and active-low output enable. A hold keeps the half's address and data registers unchanged. The output enable acts combinationally on a per-half valid flag, which stands in for a tri-state bus.

A lane writes only if its select was also low on the edge before. The usual sequence is therefore one deselected "arming" cycle with the select low, followed by the selected write cycles. A deselected half still captures address and data, so data can be staged before the half is selected. The result is undefined when both ports write the same lane of the same word on the same cycle.

Top module: `dual_lane_ram`

## Requirements
- R1: While reset is high and on the cycle after it, both `rvalid` bits and the whole of `rdata` are 0 on that port.
- R2: A read is a cycle in which the half is selected (`sel_n[h]`=0) and both lanes of that half have `rw_n`=1 at edge k. It returns the addressed lanes on `rdata` after edge k+1, with `rvalid[h]`=1 when `oe_n[h]`=0. Between edge k and edge k+1, `rvalid[h]` is still 0.
- R3: Lane i covers bits 9i+8..9i and is controlled by `rw_n[i]`, where 0 means write. A write cycle changes only the lanes whose registered `rw_n` bit is 0, and leaves the other lanes of the word unchanged.
- R4: A lane whose `rw_n` bit was 1 at the edge before the write cycle's edge does not write, even with its half selected and its `rw_n` at 0.
- R5: `sel_n[0]` governs lanes 0–1 and `sel_n[1]` governs lanes 2–3. A half with `sel_n`=1 neither writes nor raises its `rvalid` bit.
- R6: A deselected half with `rw_n`=0 still loads its address and data registers. A following selected cycle whose hold is high writes the data captured during the deselected cycle.
- R7: `hold[h]`=1 at an edge keeps the address and data registers of half h and lets the other half load. Each half then writes with its own registered address and data.
- R8: `rvalid[h]` is 0 whenever `oe_n[h]`=1, and `oe_n` acts without a clock edge. The `rdata` bits of a half whose `rvalid` bit is 0 read as 0.
- R9: Each port can read a word written by the other port, and the two ports can run traffic at the same time on different clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk | input | 1 | Port A clock |
| a_rst | input | 1 | Port A synchronous reset, active high |
| a_addr | input | 12 | Port A word address |
| a_wdata | input | 36 | Port A write data |
| a_rw_n | input | 4 | Port A per-lane select, 0 = write, 1 = read |
| a_sel_n | input | 2 | Port A per-half chip select, active low |
| a_hold | input | 2 | Port A per-half input hold, active high |
| a_oe_n | input | 2 | Port A per-half output enable, active low, asynchronous |
| a_rdata | output | 36 | Port A read data |
| a_rvalid | output | 2 | Port A per-half read data valid |
| b_clk | input | 1 | Port B clock |
| b_rst | input | 1 | Port B synchronous reset, active high |
| b_addr | input | 12 | Port B word address |
| b_wdata | input | 36 | Port B write data |
| b_rw_n | input | 4 | Port B per-lane select, 0 = write, 1 = read |
| b_sel_n | input | 2 | Port B per-half chip select, active low |
| b_hold | input | 2 | Port B per-half input hold, active high |
| b_oe_n | input | 2 | Port B per-half output enable, active low, asynchronous |
| b_rdata | output | 36 | Port B read data |
| b_rvalid | output | 2 | Port B per-half read data valid |

## Verification
The bench builds the block with its default parameters: 12 address bits and 9-bit lanes. At that size, the first and last word of the array can be written from one port and read from the other. Port A runs on a 5 ns clock and port B on an unrelated 7 ns clock. Random writes with random lane masks go to disjoint address halves on the two ports at the same time, and cross-port reads follow. Directed sequences cover the arming rule, split holds, deselected staging and asynchronous output enable.

// File: rtl/lane_ram_pkg.sv
package lane_ram_pkg;

    localparam int LANES          = 4;
    localparam int HALVES         = 2;
    localparam int LANES_PER_HALF = LANES / HALVES;

    typedef struct packed {
        logic [LANES-1:0] wr;
        logic [LANES-1:0] rd;
    } lane_cmd_t;

    function automatic int half_of(input int lane);
        return lane / LANES_PER_HALF;
    endfunction

endpackage

// File: rtl/lane_port_front.sv
module lane_port_front
    import lane_ram_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int LANE_W = 9,
    localparam int WORD_W = LANE_W * LANES
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [WORD_W-1:0]              wdata,
    input  logic [LANES-1:0]               rw_n,
    input  logic [HALVES-1:0]              sel_n,
    input  logic [HALVES-1:0]              hold,
    output logic [HALVES-1:0][ADDR_W-1:0]  addr_q,
    output logic [WORD_W-1:0]              wdata_q,
    output lane_cmd_t                      cmd,
    output logic [HALVES-1:0]              rd_half
);

    localparam int HALF_W = LANE_W * LANES_PER_HALF;

    logic [HALVES-1:0] sel_q;
    logic [LANES-1:0]  rw_q;
    logic [LANES-1:0]  rw_prev;

    // Address and data registers, one set per half, stalled by hold
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            for (int h = 0; h < HALVES; h++) begin
                if (!hold[h]) begin
                    addr_q[h]                    <= addr;
                    wdata_q[h*HALF_W +: HALF_W]  <= wdata[h*HALF_W +: HALF_W];
                end
            end
        end
    end

    // Control registers load every edge; rw_prev remembers one edge further back
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= '1;
            rw_q    <= '1;
            rw_prev <= '1;
        end else begin
            sel_q   <= sel_n;
            rw_q    <= rw_n;
            rw_prev <= rw_q;
        end
    end

    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            cmd.wr[l] = !sel_q[half_of(l)] && !rw_q[l] && !rw_prev[l];
            cmd.rd[l] = !sel_q[half_of(l)] &&  rw_q[l];
        end
        for (int h = 0; h < HALVES; h++) begin
            rd_half[h] = !sel_q[h] && (&rw_q[h*LANES_PER_HALF +: LANES_PER_HALF]);
        end
    end

endmodule

// File: rtl/lane_store.sv
module lane_store
    import lane_ram_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int LANE_W = 9,
    localparam int WORD_W = LANE_W * LANES
) (
    input  logic                           a_clk,
    input  logic [LANES-1:0]               a_we,
    input  logic [HALVES-1:0][ADDR_W-1:0]  a_addr,
    input  logic [WORD_W-1:0]              a_wd,
    output logic [WORD_W-1:0]              a_rd,
    input  logic                           b_clk,
    input  logic [LANES-1:0]               b_we,
    input  logic [HALVES-1:0][ADDR_W-1:0]  b_addr,
    input  logic [WORD_W-1:0]              b_wd,
    output logic [WORD_W-1:0]              b_rd
);

    localparam int DEPTH = 1 << ADDR_W;

    // Each lane has one bank per port. The stored value is the XOR of both
    // banks, so each bank has a single writer and lives in a single domain.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam int H = half_of(l);

        logic [LANE_W-1:0] bank_a [DEPTH];
        logic [LANE_W-1:0] bank_b [DEPTH];

        always_ff @(posedge a_clk) begin
            if (a_we[l]) begin
                bank_a[a_addr[H]] <= a_wd[l*LANE_W +: LANE_W] ^ bank_b[a_addr[H]];
            end
        end

        always_ff @(posedge b_clk) begin
            if (b_we[l]) begin
                bank_b[b_addr[H]] <= b_wd[l*LANE_W +: LANE_W] ^ bank_a[b_addr[H]];
            end
        end

        assign a_rd[l*LANE_W +: LANE_W] = bank_a[a_addr[H]] ^ bank_b[a_addr[H]];
        assign b_rd[l*LANE_W +: LANE_W] = bank_a[b_addr[H]] ^ bank_b[b_addr[H]];
    end

endmodule

// File: rtl/lane_port_read.sv
module lane_port_read
    import lane_ram_pkg::*;
#(
    parameter int LANE_W = 9,
    localparam int WORD_W = LANE_W * LANES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LANES-1:0]  rd_lane,
    input  logic [HALVES-1:0] rd_half,
    input  logic [WORD_W-1:0] mem_word,
    input  logic [HALVES-1:0] oe_n,
    output logic [WORD_W-1:0] rdata,
    output logic [HALVES-1:0] rvalid
);

    logic [WORD_W-1:0] data_q;
    logic [HALVES-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            rd_q   <= '0;
        end else begin
            rd_q <= rd_half;
            for (int l = 0; l < LANES; l++) begin
                if (rd_lane[l]) begin
                    data_q[l*LANE_W +: LANE_W] <= mem_word[l*LANE_W +: LANE_W];
                end
            end
        end
    end

    always_comb begin
        rvalid = rd_q & ~oe_n;
        for (int l = 0; l < LANES; l++) begin
            rdata[l*LANE_W +: LANE_W] = rvalid[half_of(l)] ? data_q[l*LANE_W +: LANE_W] : '0;
        end
    end

endmodule

// File: rtl/dual_lane_ram.sv
module dual_lane_ram
    import lane_ram_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int LANE_W = 9,
    localparam int WORD_W = LANE_W * LANES
) (
    input  logic              a_clk,
    input  logic              a_rst,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [WORD_W-1:0] a_wdata,
    input  logic [LANES-1:0]  a_rw_n,
    input  logic [HALVES-1:0] a_sel_n,
    input  logic [HALVES-1:0] a_hold,
    input  logic [HALVES-1:0] a_oe_n,
    output logic [WORD_W-1:0] a_rdata,
    output logic [HALVES-1:0] a_rvalid,
    input  logic              b_clk,
    input  logic              b_rst,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [WORD_W-1:0] b_wdata,
    input  logic [LANES-1:0]  b_rw_n,
    input  logic [HALVES-1:0] b_sel_n,
    input  logic [HALVES-1:0] b_hold,
    input  logic [HALVES-1:0] b_oe_n,
    output logic [WORD_W-1:0] b_rdata,
    output logic [HALVES-1:0] b_rvalid
);

    logic [HALVES-1:0][ADDR_W-1:0] addr_a_q, addr_b_q;
    logic [WORD_W-1:0]             wdata_a_q, wdata_b_q;
    lane_cmd_t                     cmd_a, cmd_b;
    logic [HALVES-1:0]             rd_half_a, rd_half_b;
    logic [WORD_W-1:0]             mem_a, mem_b;

    lane_port_front #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_front_a (
        .clk(a_clk), .rst(a_rst), .addr(a_addr), .wdata(a_wdata),
        .rw_n(a_rw_n), .sel_n(a_sel_n), .hold(a_hold),
        .addr_q(addr_a_q), .wdata_q(wdata_a_q), .cmd(cmd_a), .rd_half(rd_half_a)
    );

    lane_port_front #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_front_b (
        .clk(b_clk), .rst(b_rst), .addr(b_addr), .wdata(b_wdata),
        .rw_n(b_rw_n), .sel_n(b_sel_n), .hold(b_hold),
        .addr_q(addr_b_q), .wdata_q(wdata_b_q), .cmd(cmd_b), .rd_half(rd_half_b)
    );

    lane_store #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_store (
        .a_clk(a_clk), .a_we(cmd_a.wr), .a_addr(addr_a_q), .a_wd(wdata_a_q), .a_rd(mem_a),
        .b_clk(b_clk), .b_we(cmd_b.wr), .b_addr(addr_b_q), .b_wd(wdata_b_q), .b_rd(mem_b)
    );

    lane_port_read #(.LANE_W(LANE_W)) u_read_a (
        .clk(a_clk), .rst(a_rst), .rd_lane(cmd_a.rd), .rd_half(rd_half_a),
        .mem_word(mem_a), .oe_n(a_oe_n), .rdata(a_rdata), .rvalid(a_rvalid)
    );

    lane_port_read #(.LANE_W(LANE_W)) u_read_b (
        .clk(b_clk), .rst(b_rst), .rd_lane(cmd_b.rd), .rd_half(rd_half_b),
        .mem_word(mem_b), .oe_n(b_oe_n), .rdata(b_rdata), .rvalid(b_rvalid)
    );

endmodule

// File: rtl/dual_lane_ram_checker.sv
module dual_lane_ram_checker #(
    parameter int WORD_W = 36
) (
    input logic              a_clk,
    input logic              a_rst,
    input logic [3:0]        a_rw_n,
    input logic [1:0]        a_sel_n,
    input logic [1:0]        a_oe_n,
    input logic [WORD_W-1:0] a_rdata,
    input logic [1:0]        a_rvalid,
    input logic [3:0]        a_wr,
    input logic              b_clk,
    input logic              b_rst,
    input logic [3:0]        b_rw_n,
    input logic [1:0]        b_oe_n,
    input logic [1:0]        b_rvalid,
    input logic [3:0]        b_wr
);

    localparam int HALF_W = WORD_W / 2;

    p_reset_clear_r1: assert property (@(posedge a_clk) a_rst |=> (a_rvalid == 2'b00));
    p_reset_clear_b_r1: assert property (@(posedge b_clk) b_rst |=> (b_rvalid == 2'b00));

    p_arm_a_r4: assert property (@(posedge a_clk) disable iff (a_rst)
        (a_wr & ($past(a_rw_n) | $past(a_rw_n, 2))) == 4'b0000);
    p_arm_b_r4: assert property (@(posedge b_clk) disable iff (b_rst)
        (b_wr & ($past(b_rw_n) | $past(b_rw_n, 2))) == 4'b0000);

    p_desel_write_lo_r5: assert property (@(posedge a_clk) disable iff (a_rst)
        $past(a_sel_n[0]) |-> (a_wr[1:0] == 2'b00));
    p_desel_write_hi_r5: assert property (@(posedge a_clk) disable iff (a_rst)
        $past(a_sel_n[1]) |-> (a_wr[3:2] == 2'b00));
    p_desel_read_r5: assert property (@(posedge a_clk) disable iff (a_rst)
        $past(a_sel_n[0], 2) |-> !a_rvalid[0]);

    p_oe_lo_r8: assert property (@(posedge a_clk) disable iff (a_rst) a_oe_n[0] |-> !a_rvalid[0]);
    p_oe_hi_r8: assert property (@(posedge a_clk) disable iff (a_rst) a_oe_n[1] |-> !a_rvalid[1]);
    p_oe_b_r8: assert property (@(posedge b_clk) disable iff (b_rst) (b_rvalid & b_oe_n) == 2'b00);
    p_zero_lo_r8: assert property (@(posedge a_clk) disable iff (a_rst)
        !a_rvalid[0] |-> (a_rdata[HALF_W-1:0] == '0));
    p_zero_hi_r8: assert property (@(posedge a_clk) disable iff (a_rst)
        !a_rvalid[1] |-> (a_rdata[WORD_W-1:HALF_W] == '0));

endmodule

bind dual_lane_ram dual_lane_ram_checker #(.WORD_W(WORD_W)) u_chk (
    .a_clk(a_clk), .a_rst(a_rst), .a_rw_n(a_rw_n), .a_sel_n(a_sel_n), .a_oe_n(a_oe_n),
    .a_rdata(a_rdata), .a_rvalid(a_rvalid), .a_wr(cmd_a.wr),
    .b_clk(b_clk), .b_rst(b_rst), .b_rw_n(b_rw_n), .b_oe_n(b_oe_n),
    .b_rvalid(b_rvalid), .b_wr(cmd_b.wr)
);

// File: tb/test_dual_lane_ram.sv
`timescale 1ns/100ps
module test_dual_lane_ram;

    logic        a_clk = 0, b_clk = 0, a_rst = 1, b_rst = 1;
    logic [11:0] a_addr = 0, b_addr = 0;
    logic [35:0] a_wdata = 0, b_wdata = 0;
    logic [3:0]  a_rw_n = 4'hF, b_rw_n = 4'hF;
    logic [1:0]  a_sel_n = 2'b11, b_sel_n = 2'b11, a_hold = 0, b_hold = 0;
    logic [1:0]  a_oe_n = 0, b_oe_n = 0;
    logic [35:0] a_rdata, b_rdata;
    logic [1:0]  a_rvalid, b_rvalid;

    int checks = 0;
    int errors = 0;
    logic [35:0] mirror [4096];
    bit          written [4096];

    always #2.5 a_clk = ~a_clk;
    always #3.5 b_clk = ~b_clk;

    dual_lane_ram i_dual_lane_ram (
        .a_clk(a_clk), .a_rst(a_rst), .a_addr(a_addr), .a_wdata(a_wdata), .a_rw_n(a_rw_n),
        .a_sel_n(a_sel_n), .a_hold(a_hold), .a_oe_n(a_oe_n), .a_rdata(a_rdata), .a_rvalid(a_rvalid),
        .b_clk(b_clk), .b_rst(b_rst), .b_addr(b_addr), .b_wdata(b_wdata), .b_rw_n(b_rw_n),
        .b_sel_n(b_sel_n), .b_hold(b_hold), .b_oe_n(b_oe_n), .b_rdata(b_rdata), .b_rvalid(b_rvalid)
    );

    task automatic chk(input string rq, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", rq, act, exp);
        end
    endtask

    function automatic logic [35:0] merge(input logic [35:0] old, input logic [35:0] nw,
                                          input logic [3:0] mask);
        logic [35:0] r = old;
        for (int l = 0; l < 4; l++) if (mask[l]) r[l*9 +: 9] = nw[l*9 +: 9];
        return r;
    endfunction

    task automatic a_drive(input logic [11:0] ad, input logic [35:0] d, input logic [3:0] rw,
                           input logic [1:0] sel, input logic [1:0] hd);
        @(negedge a_clk);
        a_addr = ad; a_wdata = d; a_rw_n = rw; a_sel_n = sel; a_hold = hd;
    endtask

    task automatic b_drive(input logic [11:0] ad, input logic [35:0] d, input logic [3:0] rw,
                           input logic [1:0] sel, input logic [1:0] hd);
        @(negedge b_clk);
        b_addr = ad; b_wdata = d; b_rw_n = rw; b_sel_n = sel; b_hold = hd;
    endtask

    // arming cycle, write cycle, idle; the write lands at the edge after the write cycle
    task automatic a_write(input logic [11:0] ad, input logic [35:0] d, input logic [3:0] mask);
        a_drive(ad, d, ~mask, 2'b11, 2'b00);
        a_drive(ad, d, ~mask, 2'b00, 2'b00);
        a_drive(12'd0, 36'd0, 4'hF, 2'b11, 2'b00);
        mirror[ad] = merge(mirror[ad], d, mask);
        written[ad] = 1;
    endtask

    task automatic b_write(input logic [11:0] ad, input logic [35:0] d, input logic [3:0] mask);
        b_drive(ad, d, ~mask, 2'b11, 2'b00);
        b_drive(ad, d, ~mask, 2'b00, 2'b00);
        b_drive(12'd0, 36'd0, 4'hF, 2'b11, 2'b00);
        mirror[ad] = merge(mirror[ad], d, mask);
        written[ad] = 1;
    endtask

    task automatic a_read(input logic [11:0] ad, input string rq);
        a_drive(ad, 36'd0, 4'hF, 2'b00, 2'b00);
        a_drive(12'd0, 36'd0, 4'hF, 2'b11, 2'b00);
        chk({rq, " R2 latency rvalid"}, {34'd0, a_rvalid}, 36'd0);
        @(negedge a_clk);
        chk({rq, " rvalid"}, {34'd0, a_rvalid}, 36'd3);
        chk({rq, " rdata"}, a_rdata, mirror[ad]);
    endtask

    task automatic b_read(input logic [11:0] ad, input string rq);
        b_drive(ad, 36'd0, 4'hF, 2'b00, 2'b00);
        b_drive(12'd0, 36'd0, 4'hF, 2'b11, 2'b00);
        chk({rq, " R2 latency rvalid"}, {34'd0, b_rvalid}, 36'd0);
        @(negedge b_clk);
        chk({rq, " rvalid"}, {34'd0, b_rvalid}, 36'd3);
        chk({rq, " rdata"}, b_rdata, mirror[ad]);
    endtask

    initial begin
        repeat (150000) @(posedge a_clk);
        errors++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [35:0] d1, d2;
        void'($urandom(32'd2024));
        repeat (4) @(negedge a_clk);
        a_rst = 0;
        repeat (2) @(negedge b_clk);
        b_rst = 0;
        @(negedge a_clk);
        chk("R1 a_rvalid", {34'd0, a_rvalid}, 36'd0);
        chk("R1 a_rdata", a_rdata, 36'd0);
        @(negedge b_clk);
        chk("R1 b_rvalid", {34'd0, b_rvalid}, 36'd0);
        chk("R1 b_rdata", b_rdata, 36'd0);

        // R2 and R9: corner addresses, cross-port
        a_write(12'd0, 36'h1_2345_6789, 4'hF);
        a_read(12'd0, "R2 addr0");
        a_write(12'd4095, 36'hF_EDCB_A987, 4'hF);
        b_read(12'd4095, "R9 addr4095");
        b_read(12'd0, "R9 addr0");
        b_write(12'd4094, 36'hA_5A5A_5A5A, 4'hF);
        a_read(12'd4094, "R9 b_to_a");

        // R3: partial lane write
        a_write(12'd5, 36'h0_0000_0000, 4'hF);
        a_write(12'd5, 36'hF_FFFF_FFFF, 4'b0101);
        a_read(12'd5, "R3 lanes 0 and 2");

        // R4: write without arming is suppressed
        a_write(12'd6, 36'h3_3333_3333, 4'hF);
        a_drive(12'd6, 36'hC_CCCC_CCCC, 4'hF, 2'b11, 2'b00);
        a_drive(12'd6, 36'hC_CCCC_CCCC, 4'h0, 2'b00, 2'b00);
        a_drive(12'd0, 36'd0, 4'hF, 2'b11, 2'b00);
        a_read(12'd6, "R4 unarmed");

        // R5: only low half selected for a write, then a low-deselected read
        a_write(12'd7, 36'h1_1111_1111, 4'hF);
        a_drive(12'd7, 36'h6_6666_6666, 4'h0, 2'b11, 2'b00);
        a_drive(12'd7, 36'h6_6666_6666, 4'h0, 2'b10, 2'b00);
        a_drive(12'd0, 36'd0, 4'hF, 2'b11, 2'b00);
        mirror[7] = merge(mirror[7], 36'h6_6666_6666, 4'b0011);
        a_read(12'd7, "R5 half write");
        a_drive(12'd7, 36'd0, 4'hF, 2'b01, 2'b00);
        a_drive(12'd0, 36'd0, 4'hF, 2'b11, 2'b00);
        @(negedge a_clk);
        chk("R5 desel read rvalid", {34'd0, a_rvalid}, 36'd2);
        chk("R5 desel read rdata", a_rdata, {mirror[7][35:18], 18'd0});

        // R6: data staged while deselected, written under hold
        a_write(12'd8, 36'h0_0F0F_0F0F, 4'hF);
        a_write(12'd9, 36'h0_F0F0_F0F0, 4'hF);
        d1 = 36'h9_8765_4321;
        a_drive(12'd8, d1, 4'h0, 2'b11, 2'b00);
        a_drive(12'd9, 36'h2_2222_2222, 4'h0, 2'b00, 2'b11);
        a_drive(12'd0, 36'd0, 4'hF, 2'b11, 2'b00);
        mirror[8] = d1;
        a_read(12'd8, "R6 staged data");
        a_read(12'd9, "R6 untouched");

        // R7: hold only the low half
        a_write(12'd10, 36'h0_0000_0000, 4'hF);
        a_write(12'd11, 36'h0_0000_0000, 4'hF);
        d1 = 36'hA_BCDE_F012; d2 = 36'h5_4321_0FED;
        a_drive(12'd10, d1, 4'h0, 2'b11, 2'b00);
        a_drive(12'd11, d2, 4'h0, 2'b00, 2'b01);
        a_drive(12'd0, 36'd0, 4'hF, 2'b11, 2'b00);
        mirror[10] = merge(mirror[10], d1, 4'b0011);
        mirror[11] = merge(mirror[11], d2, 4'b1100);
        a_read(12'd10, "R7 held low half");
        a_read(12'd11, "R7 loaded high half");

        // R8: asynchronous output enable
        a_write(12'd12, 36'h7_1357_9BDF, 4'hF);
        a_drive(12'd12, 36'd0, 4'hF, 2'b00, 2'b00);
        a_drive(12'd0, 36'd0, 4'hF, 2'b11, 2'b00);
        @(negedge a_clk);
        a_oe_n = 2'b01;
        #1;
        chk("R8 oe low half off rvalid", {34'd0, a_rvalid}, 36'd2);
        chk("R8 oe low half off rdata", a_rdata, {mirror[12][35:18], 18'd0});
        a_oe_n = 2'b00;
        #1;
        chk("R8 oe on rvalid", {34'd0, a_rvalid}, 36'd3);
        chk("R8 oe on rdata", a_rdata, mirror[12]);

        // R9 and R3: concurrent random traffic on disjoint halves of the array
        fork
            begin
                logic [11:0] ad; logic [3:0] m;
                repeat (150) begin
                    ad = 12'($urandom_range(0, 2047));
                    m = written[ad] ? 4'($urandom_range(1, 15)) : 4'hF;
                    a_write(ad, {$urandom, 4'($urandom)}, m);
                    if ($urandom_range(0, 2) == 0) a_read(ad, "R3 random A");
                end
            end
            begin
                logic [11:0] ad; logic [3:0] m;
                repeat (110) begin
                    ad = 12'($urandom_range(2048, 4095));
                    m = written[ad] ? 4'($urandom_range(1, 15)) : 4'hF;
                    b_write(ad, {$urandom, 4'($urandom)}, m);
                    if ($urandom_range(0, 2) == 0) b_read(ad, "R3 random B");
                end
            end
        join

        for (int i = 0; i < 60; i++) begin
            logic [11:0] ad;
            do ad = 12'($urandom_range(0, 2047)); while (!written[ad]);
            b_read(ad, "R9 cross A to B");
            do ad = 12'($urandom_range(2048, 4095)); while (!written[ad]);
            a_read(ad, "R9 cross B to A");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule